// File: doc/BRIEF.md
# Doubleword Load Execute Unit

This unit executes one 64-bit load instruction at a time. It accepts a 32-bit instruction word and its program counter over a valid/ready handshake. It decodes four load forms: displacement, displacement with update, indexed, and indexed with update. It reads the base and index operands from the register file that sits beside it, through two combinational read ports. It then forms a 32-bit effective address and fetches the eight bytes starting there through a doubleword-wide memory port.

The memory port is aligned. When the address is not a multiple of eight, the unit issues two aligned reads and splices the bytes from both. The result goes out on a destination write port. The update forms then write the effective address back to the base register on a second write port, in the following cycle.

A completion pulse carries the next program counter and a flag for invalid update forms. Words outside the four encodings raise a one-cycle illegal pulse and have no other effect. Back-pressure works as follows. `insn_ready` is high only while the unit is idle, so an instruction is taken on a cycle where valid and ready are both high. A memory request holds its address until `mem_req_ready` is seen. Exactly one response is expected per accepted request, and it must come at least one cycle after acceptance.

Top module: `dwl_load_unit`

## Requirements
- R1: Instruction bit 0 is the word's MSB (`insn_word[31]`). Decoding uses these fields:
  - Bits 0-5 hold the primary opcode.
  - Bits 6-10 name the destination register.
  - Bits 11-15 name the base register.
  - Bits 16-20 name the index register.

  Opcode 58 with bits 30-31 equal to 0 is the displacement load; with bits 30-31 equal to 1 it is the displacement load with update. Opcode 31 with bit 31 clear and bits 21-30 equal to 21 is the indexed load; with bits 21-30 equal to 53 it is the indexed load with update.
- R2: Any other word pulses `illegal` for one cycle, starting the cycle after acceptance. It issues no memory request and no register write.
- R3: In displacement forms, bits 16-29 form a signed 14-bit value. This value is shifted left by two and sign-extended to 64 bits to make the offset. Indexed forms use the index register's value as the offset.
- R4: In the non-update forms, a base register number of 0 gives a base of zero. The update forms always use the base register's contents, even for register 0.
- R5: The effective address is the low 32 bits of base plus offset. The base write-back carries this address zero-extended to 64 bits.
- R6: The loaded value is the eight bytes from EA to EA+7, with the byte at EA in the most significant position.
- R7: Every memory request address is a multiple of 8. An aligned EA takes one read. Any other EA takes two reads, at `EA & ~7` and then at that address plus 8 (modulo 2^32).
- R8: In update forms, the destination is written first and the base register one cycle later. So when the base equals the destination, the register ends up holding the address. `bad_form` is raised with `done` when an update form names base 0 or base equal to the destination.
- R9: `done` pulses for one cycle on the last register write of a legal instruction, and `next_pc` then equals the accepted PC plus 4.
- R10: `insn_ready` stays low while `busy` is high, so no instruction is taken mid-operation. A memory request that is not accepted keeps its valid and address unchanged.

## Ports
| Port | Direction | Width | Description |
| --- | --- | --- | --- |
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| insn_valid | input | 1 | Instruction offered |
| insn_ready | output | 1 | Unit can take an instruction |
| insn_word | input | 32 | Instruction word |
| insn_pc | input | AW | Address of the instruction |
| rf_a_addr | output | 5 | Base register read address |
| rf_a_data | input | XLEN | Base register value |
| rf_b_addr | output | 5 | Index register read address |
| rf_b_data | input | XLEN | Index register value |
| mem_req_valid | output | 1 | Memory read request |
| mem_req_ready | input | 1 | Memory accepts the request |
| mem_req_addr | output | AW | Aligned doubleword address |
| mem_rsp_valid | input | 1 | Read data returned |
| mem_rsp_data | input | XLEN | Doubleword, lowest address in the top byte |
| wr_dst_en | output | 1 | Destination write strobe |
| wr_dst_addr | output | 5 | Destination register |
| wr_dst_data | output | XLEN | Loaded value |
| wr_base_en | output | 1 | Base write-back strobe |
| wr_base_addr | output | 5 | Base register |
| wr_base_data | output | XLEN | Effective address, zero-extended |
| busy | output | 1 | Instruction in progress |
| done | output | 1 | Completion pulse |
| illegal | output | 1 | Unrecognised word pulse |
| bad_form | output | 1 | Invalid update form, valid with done |
| next_pc | output | AW | PC plus 4, valid with done |

## Verification
Each kind of internal fault shows up at the ports within the instruction that triggers it:
- A corrupted latched address shows on the very next memory request, or on the base write-back a few cycles later.
- A wrong byte offset in the splice shows in the destination data at completion.
- A wrong state sequence shows as a missing, repeated or misordered write strobe.
- A stuck state shows as `busy` held high and `insn_ready` held low.

Because the bench keeps its own copy of the register file, a bad write is also caught on the next instruction that reads the register it touched.

// File: rtl/dwl_pkg.sv
package dwl_pkg;
  localparam int REG_AW = 5;

  localparam logic [5:0] OPC_DISP = 6'd58;
  localparam logic [5:0] OPC_IDX  = 6'd31;
  localparam logic [9:0] XO_IDX   = 10'd21;
  localparam logic [9:0] XO_IDXU  = 10'd53;

  typedef enum logic [2:0] {
    ST_IDLE, ST_RD_LO, ST_WT_LO, ST_RD_HI, ST_WT_HI, ST_WB_DST, ST_WB_BASE
  } dwl_state_e;

  typedef struct packed {
    logic              legal;
    logic              indexed;
    logic              update;
    logic [REG_AW-1:0] rt;
    logic [REG_AW-1:0] ra;
    logic [REG_AW-1:0] rb;
    logic [13:0]       disp;
  } dwl_dec_t;
endpackage

// File: rtl/dwl_decode.sv
module dwl_decode
  import dwl_pkg::*;
(
  input  logic [31:0] word,
  output dwl_dec_t    dec
);
  logic [5:0] opc;
  logic [9:0] xo10;
  logic [1:0] xo2;

  assign opc  = word[31:26];
  assign xo10 = word[10:1];
  assign xo2  = word[1:0];

  always_comb begin
    dec         = '0;
    dec.rt      = word[25:21];
    dec.ra      = word[20:16];
    dec.rb      = word[15:11];
    dec.disp    = word[15:2];
    if (opc == OPC_DISP && !xo2[1]) begin
      dec.legal  = 1'b1;
      dec.update = xo2[0];
    end else if (opc == OPC_IDX && !word[0] && (xo10 == XO_IDX || xo10 == XO_IDXU)) begin
      dec.legal   = 1'b1;
      dec.indexed = 1'b1;
      dec.update  = (xo10 == XO_IDXU);
    end
  end
endmodule

// File: rtl/dwl_agu.sv
module dwl_agu
  import dwl_pkg::*;
#(
  parameter int XLEN = 64,
  parameter int AW   = 32
) (
  input  logic              indexed,
  input  logic              update,
  input  logic [REG_AW-1:0] ra,
  input  logic [REG_AW-1:0] rt,
  input  logic [13:0]       disp,
  input  logic [XLEN-1:0]   a_val,
  input  logic [XLEN-1:0]   b_val,
  output logic [AW-1:0]     ea,
  output logic              bad_form
);
  logic [XLEN-1:0] base, offs, sum;

  assign base     = (update || ra != '0) ? a_val : '0;
  assign offs     = indexed ? b_val : {{(XLEN-16){disp[13]}}, disp, 2'b00};
  assign sum      = base + offs;
  assign ea       = sum[AW-1:0];
  assign bad_form = update && (ra == '0 || ra == rt);
endmodule

// File: rtl/dwl_merge.sv
module dwl_merge #(
  parameter int XLEN = 64,
  localparam int BYTES = XLEN / 8,
  localparam int OFSW  = $clog2(BYTES)
) (
  input  logic [XLEN-1:0] lo,
  input  logic [XLEN-1:0] hi,
  input  logic [OFSW-1:0] sh,
  output logic [XLEN-1:0] out
);
  localparam int BSW = OFSW + 1;
  logic [7:0] lanes [2*BYTES];

  for (genvar i = 0; i < 2*BYTES; i++) begin : g_lane
    if (i < BYTES) begin : g_lo
      assign lanes[i] = lo[XLEN-1-8*i -: 8];
    end else begin : g_hi
      assign lanes[i] = hi[XLEN-1-8*(i-BYTES) -: 8];
    end
  end

  for (genvar k = 0; k < BYTES; k++) begin : g_out
    localparam logic [BSW-1:0] KK = BSW'(k);
    assign out[XLEN-1-8*k -: 8] = lanes[KK + {1'b0, sh}];
  end
endmodule

// File: rtl/dwl_load_unit.sv
module dwl_load_unit
  import dwl_pkg::*;
#(
  parameter int XLEN = 64,
  parameter int AW   = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              insn_valid,
  output logic              insn_ready,
  input  logic [31:0]       insn_word,
  input  logic [AW-1:0]     insn_pc,
  output logic [REG_AW-1:0] rf_a_addr,
  input  logic [XLEN-1:0]   rf_a_data,
  output logic [REG_AW-1:0] rf_b_addr,
  input  logic [XLEN-1:0]   rf_b_data,
  output logic              mem_req_valid,
  input  logic              mem_req_ready,
  output logic [AW-1:0]     mem_req_addr,
  input  logic              mem_rsp_valid,
  input  logic [XLEN-1:0]   mem_rsp_data,
  output logic              wr_dst_en,
  output logic [REG_AW-1:0] wr_dst_addr,
  output logic [XLEN-1:0]   wr_dst_data,
  output logic              wr_base_en,
  output logic [REG_AW-1:0] wr_base_addr,
  output logic [XLEN-1:0]   wr_base_data,
  output logic              busy,
  output logic              done,
  output logic              illegal,
  output logic              bad_form,
  output logic [AW-1:0]     next_pc
);
  localparam int BYTES = XLEN / 8;
  localparam int OFSW  = $clog2(BYTES);

  dwl_state_e        state;
  dwl_dec_t          dec;
  logic [AW-1:0]     ea_c, ea_q, pc_q;
  logic              bad_c, bad_q, upd_q, ill_q;
  logic [REG_AW-1:0] rt_q, ra_q;
  logic [XLEN-1:0]   lo_q, hi_q, merged;
  logic              accept;

  dwl_decode u_dec (.word(insn_word), .dec(dec));

  dwl_agu #(.XLEN(XLEN), .AW(AW)) u_agu (
    .indexed(dec.indexed), .update(dec.update), .ra(dec.ra), .rt(dec.rt),
    .disp(dec.disp), .a_val(rf_a_data), .b_val(rf_b_data),
    .ea(ea_c), .bad_form(bad_c)
  );

  dwl_merge #(.XLEN(XLEN)) u_merge (
    .lo(lo_q), .hi(hi_q), .sh(ea_q[OFSW-1:0]), .out(merged)
  );

  assign rf_a_addr  = dec.ra;
  assign rf_b_addr  = dec.rb;
  assign busy       = (state != ST_IDLE);
  assign insn_ready = !busy;
  assign accept     = insn_valid && insn_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= ST_IDLE;
      ill_q <= 1'b0;
      ea_q  <= '0;
      pc_q  <= '0;
      bad_q <= 1'b0;
      upd_q <= 1'b0;
      rt_q  <= '0;
      ra_q  <= '0;
      lo_q  <= '0;
      hi_q  <= '0;
    end else begin
      ill_q <= 1'b0;
      unique case (state)
        ST_IDLE: begin
          if (accept && !dec.legal) ill_q <= 1'b1;
          if (accept && dec.legal) begin
            ea_q  <= ea_c;
            pc_q  <= insn_pc;
            bad_q <= bad_c;
            upd_q <= dec.update;
            rt_q  <= dec.rt;
            ra_q  <= dec.ra;
            state <= ST_RD_LO;
          end
        end
        ST_RD_LO: if (mem_req_ready) state <= ST_WT_LO;
        ST_WT_LO: if (mem_rsp_valid) begin
          lo_q  <= mem_rsp_data;
          state <= (ea_q[OFSW-1:0] == '0) ? ST_WB_DST : ST_RD_HI;
        end
        ST_RD_HI: if (mem_req_ready) state <= ST_WT_HI;
        ST_WT_HI: if (mem_rsp_valid) begin
          hi_q  <= mem_rsp_data;
          state <= ST_WB_DST;
        end
        ST_WB_DST:  state <= upd_q ? ST_WB_BASE : ST_IDLE;
        ST_WB_BASE: state <= ST_IDLE;
        default:    state <= ST_IDLE;
      endcase
    end
  end

  assign mem_req_valid = (state == ST_RD_LO) || (state == ST_RD_HI);
  assign mem_req_addr  = {ea_q[AW-1:OFSW], {OFSW{1'b0}}}
                       + ((state == ST_RD_HI) ? AW'(BYTES) : '0);

  assign wr_dst_en    = (state == ST_WB_DST);
  assign wr_dst_addr  = rt_q;
  assign wr_dst_data  = merged;
  assign wr_base_en   = (state == ST_WB_BASE);
  assign wr_base_addr = ra_q;
  assign wr_base_data = {{(XLEN-AW){1'b0}}, ea_q};

  assign done     = (wr_dst_en && !upd_q) || wr_base_en;
  assign bad_form = done && bad_q;
  assign illegal  = ill_q;
  assign next_pc  = pc_q + AW'(4);
endmodule

// File: rtl/dwl_load_unit_chk.sv
module dwl_load_unit_chk #(
  parameter int AW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          mem_req_valid,
  input logic          mem_req_ready,
  input logic [AW-1:0] mem_req_addr,
  input logic          wr_dst_en,
  input logic          wr_base_en,
  input logic          illegal,
  input logic          done,
  input logic          busy
);
  // R7
  aligned_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid |-> mem_req_addr[2:0] == 3'b000);

  // R10
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_req_addr));

  // R2
  illegal_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    illegal |-> !mem_req_valid && !wr_dst_en && !wr_base_en);

  // R8
  base_after_dst_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_base_en |-> $past(wr_dst_en));

  // R9
  done_ends_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !busy);
endmodule

bind dwl_load_unit dwl_load_unit_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .mem_req_valid(mem_req_valid),
  .mem_req_ready(mem_req_ready), .mem_req_addr(mem_req_addr),
  .wr_dst_en(wr_dst_en), .wr_base_en(wr_base_en), .illegal(illegal),
  .done(done), .busy(busy)
);

// File: tb/dwl_load_unit_tb.sv
module dwl_load_unit_tb;
  localparam int XLEN = 64;
  localparam int AW   = 32;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rst_n, insn_valid, insn_ready;
  logic [31:0] insn_word;
  logic [AW-1:0] insn_pc, mem_req_addr, next_pc;
  logic [4:0] rf_a_addr, rf_b_addr, wr_dst_addr, wr_base_addr;
  logic [XLEN-1:0] rf_a_data, rf_b_data, mem_rsp_data, wr_dst_data, wr_base_data;
  logic mem_req_valid, mem_req_ready, mem_rsp_valid;
  logic wr_dst_en, wr_base_en, busy, done, illegal, bad_form;

  logic [63:0] regs [32];
  assign rf_a_data = regs[rf_a_addr];
  assign rf_b_data = regs[rf_b_addr];

  dwl_load_unit #(.XLEN(XLEN), .AW(AW)) u_dut (.*);

  int n_chk = 0, n_bad = 0, mem_acc = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic logic [7:0] mbyte(input logic [31:0] a);
    return (a[7:0] * 8'd29) ^ a[15:8] ^ (a[23:16] * 8'd3) ^ (a[31:24] + 8'h6b);
  endfunction

  function automatic logic [63:0] mload(input logic [31:0] a);
    logic [63:0] d = '0;
    for (int k = 0; k < 8; k++) d = {d[55:0], mbyte(a + 32'(k))};
    return d;
  endfunction

  function automatic logic [31:0] enc_ds(input logic [4:0] rt, input logic [4:0] ra,
                                         input logic [13:0] ds, input logic [1:0] xo);
    return {6'd58, rt, ra, ds, xo};
  endfunction

  function automatic logic [31:0] enc_x(input logic [4:0] rt, input logic [4:0] ra,
                                        input logic [4:0] rb, input logic [9:0] xo);
    return {6'd31, rt, ra, rb, xo, 1'b0};
  endfunction

  // memory responder: random acceptance, random latency, one outstanding
  initial begin
    bit pend = 0, acc_next = 0;
    int cnt = 0;
    logic [31:0] pa = '0, la = '0;
    mem_req_ready = 0; mem_rsp_valid = 0; mem_rsp_data = '0;
    forever begin
      @(negedge clk);
      mem_rsp_valid = 0;
      if (pend) begin
        if (cnt == 0) begin
          mem_rsp_valid = 1; mem_rsp_data = mload(pa); pend = 0;
        end else cnt--;
      end
      if (acc_next) begin
        pend = 1; cnt = $urandom % 3; pa = la; acc_next = 0;
      end
      mem_req_ready = (($urandom % 4) != 0) && !pend;
      if (mem_req_ready && mem_req_valid && rst_n) begin
        acc_next = 1; la = mem_req_addr; mem_acc++;
      end
    end
  end

  initial begin
    #(5.0 * 150000);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  bit ready_busy_seen = 0;

  task automatic run(input logic [31:0] w, input logic [31:0] pc);
    logic [5:0] opc = w[31:26];
    logic [4:0] rt = w[25:21], ra = w[20:16], rb = w[15:11];
    logic [9:0] xo = w[10:1];
    bit legal, upd, idx, bad;
    logic [63:0] base, offs, exp_d;
    logic [31:0] ea;
    bit got_d = 0, got_b = 0, s_ill = 0, s_done = 0, s_bf = 0, order_ok = 1;
    logic [4:0] da = '0, ba = '0;
    logic [63:0] dd = '0, bd = '0;
    logic [31:0] npc = '0;
    int acc0;
    legal = (opc == 6'd58 && !w[1]) || (opc == 6'd31 && !w[0] && (xo == 10'd21 || xo == 10'd53));
    idx   = (opc == 6'd31);
    upd   = idx ? (xo == 10'd53) : w[0];
    base  = (upd || ra != 0) ? regs[ra] : 64'd0;
    offs  = idx ? regs[rb] : {{48{w[15]}}, w[15:2], 2'b00};
    ea    = 32'(base + offs);
    exp_d = mload(ea);
    bad   = upd && (ra == 0 || ra == rt);

    @(negedge clk);
    while (!insn_ready) @(negedge clk);
    insn_word = w; insn_pc = pc; insn_valid = 1;
    acc0 = mem_acc;
    @(negedge clk);
    insn_valid = 0;
    for (int c = 0; c < 200; c++) begin
      if (wr_dst_en) begin got_d = 1; da = wr_dst_addr; dd = wr_dst_data; end
      if (wr_base_en) begin
        if (!got_d) order_ok = 0;
        got_b = 1; ba = wr_base_addr; bd = wr_base_data;
      end
      if (illegal) s_ill = 1;
      if (busy && insn_ready) ready_busy_seen = 1;
      if (done) begin s_done = 1; npc = next_pc; s_bf = bad_form; end
      if (s_done || s_ill) break;
      @(negedge clk);
    end

    if (!legal) begin
      // R2: pulse, no access, no write, single cycle
      chk(s_ill, "R2", "illegal pulse", 64'(s_ill), 64'd1);
      @(negedge clk);
      chk(!illegal, "R2", "illegal one cycle", 64'(illegal), 64'd0);
      chk(!got_d && !got_b && !wr_dst_en && !wr_base_en && mem_acc == acc0,
          "R2", "no side effects", 64'(mem_acc - acc0), 64'd0);
      return;
    end

    chk(s_done && !s_ill, "R1", "legal decode completes", 64'(s_done), 64'd1);
    chk(got_d && da == rt, "R1", "dest register", 64'(da), 64'(rt));
    chk(dd == exp_d, (ea[2:0] != 0) ? "R7" : "R6", "loaded data", dd, exp_d);
    chk(npc == pc + 32'd4, "R9", "next pc", 64'(npc), 64'(pc + 32'd4));
    chk(s_bf == bad, "R8", "bad form flag", 64'(s_bf), 64'(bad));
    chk(got_b == upd, "R8", "base write present", 64'(got_b), 64'(upd));
    if (got_d) regs[da] = dd;
    if (upd) begin
      chk(order_ok && ba == ra, "R8", "base write order/addr", 64'(ba), 64'(ra));
      chk(bd == {32'd0, ea}, "R5", "base write-back EA", bd, {32'd0, ea});
      if (got_b) regs[ba] = bd;
      chk(regs[rt] == ((ra == rt) ? {32'd0, ea} : exp_d), "R8", "final dest value",
          regs[rt], (ra == rt) ? {32'd0, ea} : exp_d);
    end
  endtask

  initial begin
    void'($urandom(32'd20250611));
    rst_n = 0; insn_valid = 0; insn_word = '0; insn_pc = '0;
    for (int i = 0; i < 32; i++) regs[i] = {$urandom, $urandom};
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(!busy && insn_ready && !done && !illegal && !mem_req_valid && !wr_dst_en && !wr_base_en,
        "R10", "reset state idle", 64'(busy), 64'd0);

    // R4 R3 R5: base 0 is literal zero, negative displacement, EA wraps; unaligned by 4
    regs[0] = 64'h0000_0000_0000_1000;
    run(enc_ds(5'd3, 5'd0, 14'h3fff, 2'd0), 32'h0000_0100);
    // R4 R8: update form with base 0 reads register 0 and flags bad form
    run(enc_ds(5'd5, 5'd0, 14'd2, 2'd1), 32'h0000_0200);
    // R8: base equals destination, address wins
    regs[7] = 64'hFFFF_FFFF_0000_2003; regs[8] = 64'd16;
    run(enc_x(5'd7, 5'd7, 5'd8, 10'd53), 32'h0000_0300);
    // R6: aligned indexed load
    regs[9] = 64'h0000_0001_0000_4000; regs[10] = 64'h8;
    run(enc_x(5'd11, 5'd9, 5'd10, 10'd21), 32'h0000_0400);
    // R7 R3: odd base, positive displacement
    regs[12] = 64'h0000_0000_0000_5003;
    run(enc_ds(5'd13, 5'd12, 14'h1fff, 2'd0), 32'h0000_0500);
    // R7: last doubleword in address space spans to address 0
    regs[14] = 64'h0000_0000_FFFF_FFF9;
    run(enc_ds(5'd15, 5'd14, 14'd0, 2'd1), 32'h0000_0600);
    // R2: near-miss encodings
    run(enc_ds(5'd1, 5'd2, 14'd4, 2'd2), 32'h700);
    run(enc_x(5'd1, 5'd2, 5'd3, 10'd22), 32'h704);
    run(enc_x(5'd1, 5'd2, 5'd3, 10'd21) | 32'd1, 32'h708);
    run(32'h0000_0000, 32'h70c);

    for (int n = 0; n < 120; n++) begin
      logic [4:0] rt = 5'($urandom), ra = 5'($urandom), rb = 5'($urandom);
      int f = $urandom % 5;
      if ($urandom % 6 == 0) ra = rt;
      if ($urandom % 8 == 0) ra = 0;
      if ($urandom % 3 == 0) regs[ra] = {$urandom, $urandom};
      case (f)
        0: run(enc_ds(rt, ra, 14'($urandom), 2'd0), $urandom);
        1: run(enc_ds(rt, ra, 14'($urandom), 2'd1), $urandom);
        2: run(enc_x(rt, ra, rb, 10'd21), $urandom);
        3: run(enc_x(rt, ra, rb, 10'd53), $urandom);
        default: run($urandom, $urandom);
      endcase
    end

    chk(!ready_busy_seen, "R10", "no ready while busy", 64'(ready_busy_seen), 64'd0);
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule